// File: doc/BRIEF.md
# Dual-Sided 16-bit Message Mailbox

This block passes 32-bit messages between a host processor and a DSP when both only have a 16-bit register bus. Each direction has one or more single-slot channels. The host sends on one channel and receives on two. A channel stores a message as two 16-bit halves:
- the low half goes in a data register;
- the high half goes in a command register.

A flag register shows whether the slot holds an unread message.

The sender writes the data half first and the command half second. Writing the command half completes the message, sets the flag and raises the receiving side's interrupt. The receiver reads the data half, then the command half. That second read frees the slot and lowers the interrupt. The sender never gets a "space free" interrupt; it polls the flag instead. Each side has its own port with a write strobe, a read strobe, a byte address, write data and registered read data.

Top module: `ipc_mailbox16`

## Requirements
- R1: While reset is held, every flag clears, both interrupts go low and both read-data outputs are zero.
- R2: A message's low half is stored at the data offset and its high half at the command offset. The receiver reads back exactly the halves that were written. The host-to-DSP channel uses data 0x00 and command 0x04.
- R3: A write to a channel's command register sets its flag, so the flag register reads 0x0001. It also raises the receiving side's interrupt on the clock edge that takes the write.
- R4: A write to the data register alone leaves the flag at 0x0000 and the interrupt low.
- R5: When the receiving side reads the command register, the flag reads 0x0000 and the interrupt goes low from that edge on. Reading the data register changes neither.
- R6: Writing a channel that already holds a message overwrites the stored halves, and the flag stays set.
- R7: The two DSP-to-host channels sit at data/command 0x08/0x0C and 0x10/0x14. The flags are at 0x18 (host-to-DSP), 0x1C and 0x20. The host interrupt is the OR of the two DSP-to-host flags, so clearing one channel leaves the interrupt high while the other is still full.
- R8: Writes from the side that does not send on a channel are ignored.
- R9: When the sending side reads the command register, the flag stays set.
- R10: A command write and a receiver command read in the same cycle leave the flag set. The read returns the command half stored before that edge.
- R11: Read data is registered: it appears the cycle after the read strobe and holds until the next read on that port. Unmapped offsets read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host registered read data |
| dsp_wr_en | input | 1 | DSP write strobe |
| dsp_rd_en | input | 1 | DSP read strobe |
| dsp_addr | input | ADDR_W | DSP byte offset |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_rdata | output | DATA_W | DSP registered read data |
| host_irq | output | 1 | Message waiting for host |
| dsp_irq | output | 1 | Message waiting for DSP |

## Verification
Every result is due one clock edge after its strobe:
- a flag change and its interrupt follow the edge that takes a command write or a receiver command read;
- read data follows the edge that takes the read strobe.

The bench drives each strobe on a falling edge and holds it for exactly one rising edge. It samples at the next falling edge, which lies after the single register stage and before the next operation. The same-cycle collision case drives both ports on one falling edge. It then checks the returned command half and the interrupt at the following falling edge.

// File: rtl/ipc_mbx_pkg.sv
// Package: shared offset arithmetic for the mailbox.
// Channel 0 carries host-to-DSP traffic; channels 1.. carry DSP-to-host traffic.
// Assumes byte offsets with one 16-bit register per 4-byte word.
package ipc_mbx_pkg;
    localparam int REG_STRIDE = 4;

    // Data-half offset of a channel
    function automatic int data_off(input int ch);
        return 2 * REG_STRIDE * ch;
    endfunction

    // Command-half offset of a channel
    function automatic int cmd_off(input int ch);
        return 2 * REG_STRIDE * ch + REG_STRIDE;
    endfunction

    // Flag offset of a channel; flags follow all message registers
    function automatic int flag_off(input int ch, input int nch);
        return 2 * REG_STRIDE * nch + REG_STRIDE * ch;
    endfunction
endpackage

// File: rtl/ipc_mbx_slot.sv
// Module: one single-slot mailbox channel.
// Holds the data half, the command half and the occupancy flag.
// A command write sets the flag, and it wins over a same-cycle receiver
// command read, which would otherwise clear it.
// Assumes the write enables already carry the ownership gating.
module ipc_mbx_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_cmd_en,
    input  logic              rd_cmd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic              flag_q
);
    // Store the message halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (wr_data_en) data_q <= wdata;
            if (wr_cmd_en)  cmd_q  <= wdata;
        end
    end

    // Track occupancy: set on command write, clear on receiver command read
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (wr_cmd_en) flag_q <= 1'b1;
        else if (rd_cmd_en) flag_q <= 1'b0;
    end

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !flag_q);
    p_cmd_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_en |=> flag_q);
    p_data_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && !wr_cmd_en && !flag_q && !rd_cmd_en) |=> !flag_q);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_en && !wr_cmd_en) |=> !flag_q);
    p_flag_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !rd_cmd_en) |=> flag_q);
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data_en |=> $stable(data_q));
endmodule

// File: rtl/ipc_mbx_port.sv
// Module: register-bus port of one side (SIDE 0 = host, SIDE 1 = DSP).
// Decodes writes and command reads into per-channel strobes, gated by
// which side sends on each channel, and registers the read data.
// Assumes the write and read strobes last one cycle per access.
module ipc_mbx_port
    import ipc_mbx_pkg::*;
#(
    parameter int SIDE   = 0,
    parameter int NCH    = 3,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NCH-1:0][DATA_W-1:0]  data_all,
    input  logic [NCH-1:0][DATA_W-1:0]  cmd_all,
    input  logic [NCH-1:0]              flag_all,
    output logic [NCH-1:0]              we_data,
    output logic [NCH-1:0]              we_cmd,
    output logic [NCH-1:0]              re_cmd,
    output logic [DATA_W-1:0]           rdata
);
    logic [DATA_W-1:0] rd_next;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam bit SENDER = (i == 0) ? (SIDE == 0) : (SIDE == 1);
        localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(data_off(i));
        localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(cmd_off(i));
        // Per-channel strobes; only the owning side writes, only the other side clears
        always_comb begin
            we_data[i] = SENDER && wr_en && (addr == A_DATA);
            we_cmd[i]  = SENDER && wr_en && (addr == A_CMD);
            re_cmd[i]  = !SENDER && rd_en && (addr == A_CMD);
        end
    end

    // Select the addressed register for reading
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(data_off(i)))     rd_next = data_all[i];
            if (addr == ADDR_W'(cmd_off(i)))      rd_next = cmd_all[i];
            if (addr == ADDR_W'(flag_off(i, NCH))) rd_next = DATA_W'(flag_all[i]);
        end
    end

    // Register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    p_one_write_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_data, we_cmd}));
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/ipc_mailbox16.sv
// Module: top of the dual-port 16-bit mailbox.
// One host-to-DSP channel and N_D2H DSP-to-host channels, each a single
// slot; each side gets one interrupt that is high while a message waits.
// Assumes ADDR_W is wide enough for the highest flag offset.
module ipc_mailbox16
    import ipc_mbx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int N_D2H  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dsp_wr_en,
    input  logic              dsp_rd_en,
    input  logic [ADDR_W-1:0] dsp_addr,
    input  logic [DATA_W-1:0] dsp_wdata,
    output logic [DATA_W-1:0] dsp_rdata,
    output logic              host_irq,
    output logic              dsp_irq
);
    localparam int NCH = 1 + N_D2H;
    localparam logic [ADDR_W-1:0] A_CMD0 = ADDR_W'(cmd_off(0));

    logic [NCH-1:0][DATA_W-1:0] data_all, cmd_all;
    logic [NCH-1:0]             flag_all;
    logic [NCH-1:0]             h_we_data, h_we_cmd, h_re_cmd;
    logic [NCH-1:0]             d_we_data, d_we_cmd, d_re_cmd;

    ipc_mbx_port #(.SIDE(0), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host_port (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .rd_en(host_rd_en),
        .addr(host_addr), .wdata(host_wdata), .data_all(data_all),
        .cmd_all(cmd_all), .flag_all(flag_all), .we_data(h_we_data),
        .we_cmd(h_we_cmd), .re_cmd(h_re_cmd), .rdata(host_rdata)
    );

    ipc_mbx_port #(.SIDE(1), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dsp_port (
        .clk(clk), .rst_n(rst_n), .wr_en(dsp_wr_en), .rd_en(dsp_rd_en),
        .addr(dsp_addr), .wdata(dsp_wdata), .data_all(data_all),
        .cmd_all(cmd_all), .flag_all(flag_all), .we_data(d_we_data),
        .we_cmd(d_we_cmd), .re_cmd(d_re_cmd), .rdata(dsp_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ipc_mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_data_en(h_we_data[i] | d_we_data[i]),
            .wr_cmd_en(h_we_cmd[i] | d_we_cmd[i]),
            .rd_cmd_en(h_re_cmd[i] | d_re_cmd[i]),
            .wdata((i == 0) ? host_wdata : dsp_wdata),
            .data_q(data_all[i]), .cmd_q(cmd_all[i]), .flag_q(flag_all[i])
        );
    end

    // Interrupts follow occupancy of the channels each side receives on
    always_comb begin
        dsp_irq  = flag_all[0];
        host_irq = |flag_all[NCH-1:1];
    end

    p_dsp_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsp_irq) |-> $past(host_wr_en && host_addr == A_CMD0));
    p_dsp_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsp_irq) |-> $past(dsp_rd_en && dsp_addr == A_CMD0));
endmodule

// File: tb/ipc_mailbox16_tb.sv
module ipc_mailbox16_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 38;

    // Vector: side, wr, addr[5:0], wdata[15:0], exp_rdata[15:0], exp_host_irq, exp_dsp_irq
    localparam logic [41:0] VEC [NV] = '{
        {1'b0,1'b1,6'h00,16'h1234,16'h0000,1'b0,1'b0}, // R4 data only
        {1'b0,1'b0,6'h18,16'h0000,16'h0000,1'b0,1'b0}, // R4 flag clear
        {1'b0,1'b1,6'h04,16'hABCD,16'h0000,1'b0,1'b1}, // R3 cmd raises irq
        {1'b1,1'b0,6'h18,16'h0000,16'h0001,1'b0,1'b1}, // R3 flag set
        {1'b1,1'b0,6'h00,16'h0000,16'h1234,1'b0,1'b1}, // R2 R5 data read keeps flag
        {1'b1,1'b0,6'h04,16'h0000,16'hABCD,1'b0,1'b0}, // R2 R5 cmd read clears
        {1'b1,1'b0,6'h18,16'h0000,16'h0000,1'b0,1'b0}, // R5 flag clear
        {1'b1,1'b1,6'h08,16'h5555,16'h0000,1'b0,1'b0}, // R7 ch1 data
        {1'b1,1'b1,6'h0C,16'h6666,16'h0000,1'b1,1'b0}, // R7 ch1 cmd
        {1'b1,1'b1,6'h14,16'h7777,16'h0000,1'b1,1'b0}, // R7 ch2 cmd
        {1'b0,1'b0,6'h1C,16'h0000,16'h0001,1'b1,1'b0}, // R7 ch1 flag
        {1'b0,1'b0,6'h08,16'h0000,16'h5555,1'b1,1'b0}, // R7 ch1 data
        {1'b0,1'b0,6'h0C,16'h0000,16'h6666,1'b1,1'b0}, // R7 ch1 read, ch2 still full
        {1'b0,1'b0,6'h1C,16'h0000,16'h0000,1'b1,1'b0}, // R7 ch1 flag clear
        {1'b0,1'b0,6'h20,16'h0000,16'h0001,1'b1,1'b0}, // R7 ch2 flag
        {1'b0,1'b0,6'h10,16'h0000,16'h0000,1'b1,1'b0}, // R7 ch2 data never written
        {1'b0,1'b0,6'h14,16'h0000,16'h7777,1'b0,1'b0}, // R7 ch2 read clears
        {1'b1,1'b1,6'h00,16'h9999,16'h0000,1'b0,1'b0}, // R8 foreign data write
        {1'b1,1'b1,6'h04,16'h9999,16'h0000,1'b0,1'b0}, // R8 foreign cmd write
        {1'b0,1'b0,6'h00,16'h0000,16'h1234,1'b0,1'b0}, // R8 data unchanged
        {1'b0,1'b0,6'h18,16'h0000,16'h0000,1'b0,1'b0}, // R8 flag unchanged
        {1'b0,1'b1,6'h0C,16'h1111,16'h0000,1'b0,1'b0}, // R8 host to ch1 ignored
        {1'b1,1'b0,6'h0C,16'h0000,16'h6666,1'b0,1'b0}, // R8 ch1 cmd unchanged
        {1'b0,1'b1,6'h04,16'h0001,16'h0000,1'b0,1'b1}, // R6 first
        {1'b0,1'b1,6'h00,16'h00AA,16'h0000,1'b0,1'b1}, // R6 overwrite data
        {1'b0,1'b1,6'h04,16'h0002,16'h0000,1'b0,1'b1}, // R6 overwrite cmd
        {1'b1,1'b0,6'h18,16'h0000,16'h0001,1'b0,1'b1}, // R6 flag stays
        {1'b1,1'b0,6'h00,16'h0000,16'h00AA,1'b0,1'b1}, // R6 new data
        {1'b1,1'b0,6'h04,16'h0000,16'h0002,1'b0,1'b0}, // R6 new cmd
        {1'b0,1'b1,6'h04,16'h0003,16'h0000,1'b0,1'b1}, // R9 setup
        {1'b0,1'b0,6'h04,16'h0000,16'h0003,1'b0,1'b1}, // R9 sender read keeps flag
        {1'b1,1'b0,6'h18,16'h0000,16'h0001,1'b0,1'b1}, // R9 flag still set
        {1'b1,1'b0,6'h04,16'h0000,16'h0003,1'b0,1'b0}, // R9 receiver clears
        {1'b1,1'b1,6'h0C,16'h4242,16'h0000,1'b1,1'b0}, // R9 ch1 setup
        {1'b1,1'b0,6'h0C,16'h0000,16'h4242,1'b1,1'b0}, // R9 DSP sender read
        {1'b0,1'b0,6'h0C,16'h0000,16'h4242,1'b0,1'b0}, // R9 host clears
        {1'b0,1'b0,6'h24,16'h0000,16'h0000,1'b0,1'b0}, // R11 unmapped
        {1'b1,1'b0,6'h3C,16'h0000,16'h0000,1'b0,1'b0}  // R11 unmapped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        dsp_wr_en = 1'b0, dsp_rd_en = 1'b0;
    logic [5:0]  dsp_addr = '0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;
    logic        host_irq, dsp_irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox16 u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_wr_en(dsp_wr_en), .dsp_rd_en(dsp_rd_en), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .host_irq(host_irq), .dsp_irq(dsp_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access held for exactly one rising edge; returns at the next falling edge
    task automatic bus_op(input bit side, input bit wr, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        if (side == 1'b0) begin
            host_wr_en = wr; host_rd_en = !wr; host_addr = a; host_wdata = d;
        end else begin
            dsp_wr_en = wr; dsp_rd_en = !wr; dsp_addr = a; dsp_wdata = d;
        end
        @(negedge clk);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        dsp_wr_en  = 1'b0; dsp_rd_en  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 host_irq", {15'b0, host_irq}, 16'h0);
        check("R1 dsp_irq", {15'b0, dsp_irq}, 16'h0);
        check("R1 host_rdata", host_rdata, 16'h0);
        check("R1 dsp_rdata", dsp_rdata, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            bus_op(v[41], v[40], v[39:34], v[33:18]);
            if (!v[40]) check($sformatf("vec%0d rdata", i), v[41] ? dsp_rdata : host_rdata, v[17:2]);
            check($sformatf("vec%0d host_irq", i), {15'b0, host_irq}, {15'b0, v[1]});
            check($sformatf("vec%0d dsp_irq", i), {15'b0, dsp_irq}, {15'b0, v[0]});
        end

        // R11 read data holds with no new strobe
        repeat (3) @(negedge clk);
        check("R11 host hold", host_rdata, 16'h0000);
        bus_op(1'b1, 1'b0, 6'h0C, 16'h0);
        repeat (4) @(negedge clk);
        check("R11 dsp hold", dsp_rdata, 16'h4242);

        // R10 same-cycle command write and receiver command read
        bus_op(1'b0, 1'b1, 6'h04, 16'h0100);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = 6'h04; host_wdata = 16'hBEEF;
        dsp_rd_en  = 1'b1; dsp_addr  = 6'h04;
        @(negedge clk);
        host_wr_en = 1'b0; dsp_rd_en = 1'b0;
        check("R10 old cmd returned", dsp_rdata, 16'h0100);
        check("R10 irq kept", {15'b0, dsp_irq}, 16'h1);
        bus_op(1'b1, 1'b0, 6'h04, 16'h0);
        check("R10 new cmd", dsp_rdata, 16'hBEEF);
        check("R10 cleared after", {15'b0, dsp_irq}, 16'h0);

        // R1 reset mid-run with a message pending
        bus_op(1'b1, 1'b1, 6'h14, 16'h0F0F);
        check("R1 pre-reset host_irq", {15'b0, host_irq}, 16'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 flag clear", {15'b0, host_irq}, 16'h0);
        check("R1 rdata clear", dsp_rdata, 16'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule